// File: doc/BRIEF.md
# Link Authentication Sequencer

This block is the transmitter-side controller for a first-generation display-link authentication handshake. It holds a five-state link status and runs the key exchange with the sink. It does not reach the sink directly. It issues read and write commands to a separate serial bus engine, streams the outgoing bytes to that engine, takes in the bytes the engine returns, and waits for the engine's completion or error report before it takes its next step. The cipher and hash engines are also outside the block. The block hands the cipher the receiver key and the R0' value, and it reads back result events and match flags.

A key-selection vector (KSV) is a 40-bit key identifier. The sequencer checks that the transmitter KSV has exactly twenty 1 bits before it starts, and it checks the receiver KSV the same way once that key has been read. A plain receiver is authenticated at the end of phase one. A repeater then goes on to a second phase: the block polls the sink's ready flag and then polls the external list-match status. Any failed attempt clears encryption and starts a new attempt automatically, up to a bounded retry budget. Every delay is counted in pulses of a millisecond tick input. The delay constants are parameters, so a simulation can run with shortened times.

The command port is a valid/ready stream. While `cmd_valid` is high and `cmd_ready` is low, the command fields do not change. Write bytes go out lowest byte first. Each byte is offered with `wr_valid` and is held until `wr_ready` is seen. Read bytes are accepted while `rd_ready` is high, and the source must hold `rd_valid`/`rd_data` until then. After the last byte, the engine answers with a single-cycle `bus_done`. At any point after the command has been accepted, it may answer with `bus_err` instead.

Top module: `auth_link_seq`

## Requirements
- R1: After reset, `link_state` is INACTIVE (1), `encrypt_en` is 0 and `cmd_valid` is 0. The state codes are NO_KEY=0, INACTIVE=1, AUTHENTICATING=2, AUTHENTICATED=3, FAILED=4.
- R2: `start_req` is acted on only in INACTIVE. If `tx_ksv` does not have exactly twenty 1 bits, the block goes to NO_KEY and stays there until reset. A start request in any other state has no effect.
- R3: An attempt issues the following commands in this order, with `cmd_write`=1 for writes: read 1 byte at offset 0x40; write 8 bytes at 0x18, which are `an_value` lowest byte first; write 5 bytes at 0x10, which are `tx_ksv` lowest byte first; read 5 bytes at 0x00.
- R4: The 5 bytes read at 0x00 form `peer_ksv`, with the first byte as the low byte. If that value does not have exactly twenty 1 bits, the attempt fails.
- R5: After the receiver KSV has been read, the block waits `R0_WAIT_MS` ticks. It then reads 2 bytes at 0x08 into `peer_r0`, with the first byte as the low byte, and pulses `r0_load` for one cycle.
- R6: After `r0_load`, the attempt passes phase one only on `auth_ok_evt` with `r0_match` high, and `encrypt_en` then rises. `auth_fail_evt`, `auth_ok_evt` without a match, or `RESULT_WAIT_MS` ticks without any event fails the attempt.
- R7: Bit 6 of the byte read at 0x40 marks a repeater. A non-repeater goes to AUTHENTICATED right after phase one.
- R8: The block polls at three points: the key wait (`key_state`==`KEY_OK_CODE`, default 4, and `an_ready`==2'b11), the repeater ready wait (bit 5 of a fresh 1-byte read at 0x40) and the list-match wait (`v_match`). Each poll makes at most `POLL_TRIES` checks, spaced `POLL_GAP_MS` ticks apart, and running out of checks fails the attempt.
- R9: A failure clears `encrypt_en` and shows FAILED for one cycle, after which a new attempt starts. The `RETRY_MAX`-th consecutive failure returns the block to INACTIVE instead. Reaching AUTHENTICATED resets the failure count to zero.
- R10: `auth_fail_evt` in AUTHENTICATED moves the block to FAILED on the next cycle, which starts re-authentication.
- R11: `abort_req` in AUTHENTICATING or FAILED moves the block to INACTIVE on the next cycle, with `encrypt_en` at 0 and no further commands issued.
- R12: While a command waits for `cmd_ready`, its fields are held. A `bus_err` after the command has been accepted fails the attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start_req | input | 1 | Request to begin authentication |
| abort_req | input | 1 | Cancel the authentication in progress |
| tx_ksv | input | 40 | Transmitter key-selection vector |
| an_value | input | 64 | Session random value An from the cipher |
| key_state | input | 3 | Cipher key status code |
| an_ready | input | 2 | Ready flags for the two An halves |
| auth_ok_evt | input | 1 | Cipher result event: check finished |
| auth_fail_evt | input | 1 | Cipher result event: link failure |
| r0_match | input | 1 | R0 comparison matched |
| v_match | input | 1 | Repeater list hash matched |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_offset | output | 8 | Sink register offset |
| cmd_len | output | 4 | Byte count |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | Write byte taken |
| wr_data | output | 8 | Write byte |
| rd_valid | input | 1 | Read byte offered |
| rd_ready | output | 1 | Read byte accepted |
| rd_data | input | 8 | Read byte |
| bus_done | input | 1 | Transaction completed |
| bus_err | input | 1 | Transaction failed |
| peer_ksv | output | 40 | Receiver KSV for the cipher |
| peer_r0 | output | 16 | R0' value for the cipher |
| r0_load | output | 1 | One-cycle strobe: `peer_r0` is valid |
| encrypt_en | output | 1 | Enable link encryption |
| repeater | output | 1 | Sink reported a repeater |
| link_state | output | 3 | Link state code |

## Verification
The sequencer is run against a set of sink and cipher profiles: a clean receiver, a clean repeater, bad transmitter and receiver keys with 19 or 21 ones, and each way the result can go (fail event, ok without a match, silence). Each profile leaves a different combination of final state, encryption flag and attempt count. Together these tell apart early rejection, bounded retries and success. For one clean run, the order of the logged commands, the bytes written, the byte order of R0' and the delay before the R0' read are all checked. Directed cases cover the following:
- a failure injected while AUTHENTICATED, with and without a count left over from earlier failures, which shows whether success clears the retry count;
- an abort in the middle of the result wait;
- a key that never becomes ready;
- a bus error;
- a start request while already authenticated.

// File: rtl/auth_pkg.sv
package auth_pkg;
  typedef enum logic [2:0] {
    LS_NOKEY  = 3'd0,
    LS_IDLE   = 3'd1,
    LS_BUSY   = 3'd2,
    LS_DONE   = 3'd3,
    LS_FAILED = 3'd4
  } link_st_e;

  typedef enum logic [3:0] {
    S_KEYWAIT, S_CAPS, S_AN, S_AKSV, S_BKSV, S_R0DLY,
    S_R0RD, S_RESULT, S_RDY, S_VMATCH, S_GAP
  } step_e;

  // sink register offsets; the sink decodes these
  localparam logic [7:0] OFF_CAPS  = 8'h40;
  localparam logic [7:0] OFF_AN    = 8'h18;
  localparam logic [7:0] OFF_TXKSV = 8'h10;
  localparam logic [7:0] OFF_RXKSV = 8'h00;
  localparam logic [7:0] OFF_R0    = 8'h08;
endpackage

// File: rtl/auth_ksv_check.sv
module auth_ksv_check #(
  parameter int W    = 40,
  parameter int ONES = 20
) (
  input  logic [W-1:0] ksv,
  output logic         ok
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(ksv[i]);
    ok = (cnt == CW'(ONES));
  end
endmodule

// File: rtl/auth_ms_timer.sv
module auth_ms_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)             cnt <= '0;
    else if (tick && cnt != limit)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);
endmodule

// File: rtl/auth_link_seq.sv
module auth_link_seq
  import auth_pkg::*;
#(
  parameter logic [2:0] KEY_OK_CODE    = 3'd4,
  parameter int         POLL_TRIES     = 100,
  parameter int         POLL_GAP_MS    = 20,
  parameter int         R0_WAIT_MS     = 125,
  parameter int         RESULT_WAIT_MS = 10000,
  parameter int         RETRY_MAX      = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_tick,
  input  logic        start_req,
  input  logic        abort_req,
  input  logic [39:0] tx_ksv,
  input  logic [63:0] an_value,
  input  logic [2:0]  key_state,
  input  logic [1:0]  an_ready,
  input  logic        auth_ok_evt,
  input  logic        auth_fail_evt,
  input  logic        r0_match,
  input  logic        v_match,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic        cmd_write,
  output logic [7:0]  cmd_offset,
  output logic [3:0]  cmd_len,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [7:0]  wr_data,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [7:0]  rd_data,
  input  logic        bus_done,
  input  logic        bus_err,
  output logic [39:0] peer_ksv,
  output logic [15:0] peer_r0,
  output logic        r0_load,
  output logic        encrypt_en,
  output logic        repeater,
  output logic [2:0]  link_state
);
  localparam int TRY_W   = $clog2(POLL_TRIES + 1);
  localparam int RTY_W   = $clog2(RETRY_MAX + 1);
  localparam int MAX_A   = (R0_WAIT_MS > POLL_GAP_MS) ? R0_WAIT_MS : POLL_GAP_MS;
  localparam int TMR_MAX = (RESULT_WAIT_MS > MAX_A) ? RESULT_WAIT_MS : MAX_A;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  link_st_e          st;
  step_e             step, ret_step;
  logic              xdata;
  logic [3:0]        idx;
  logic [63:0]       cap;
  logic [TRY_W-1:0]  tries;
  logic [RTY_W-1:0]  retries;

  // command decode per step
  logic is_bus, op_wr;
  logic [7:0] off;
  logic [3:0] len;
  always_comb begin
    is_bus = 1'b1; op_wr = 1'b0; off = OFF_CAPS; len = 4'd1;
    case (step)
      S_CAPS, S_RDY: begin off = OFF_CAPS; len = 4'd1; end
      S_AN:          begin op_wr = 1'b1; off = OFF_AN; len = 4'd8; end
      S_AKSV:        begin op_wr = 1'b1; off = OFF_TXKSV; len = 4'd5; end
      S_BKSV:        begin off = OFF_RXKSV; len = 4'd5; end
      S_R0RD:        begin off = OFF_R0; len = 4'd2; end
      default:       is_bus = 1'b0;
    endcase
  end

  logic        in_bus, xfer_end, xfer_bad;
  logic [63:0] wr_src;
  assign in_bus     = is_bus && (st == LS_BUSY);
  assign cmd_valid  = in_bus && !xdata;
  assign cmd_write  = op_wr;
  assign cmd_offset = off;
  assign cmd_len    = len;
  assign wr_src     = (step == S_AN) ? an_value : {24'd0, tx_ksv};
  assign wr_valid   = in_bus && xdata && op_wr && (idx < len);
  assign wr_data    = wr_src[{idx[2:0], 3'b000} +: 8];
  assign rd_ready   = in_bus && xdata && !op_wr && (idx < len);
  assign xfer_end   = in_bus && xdata && (idx == len) && bus_done;
  assign xfer_bad   = in_bus && xdata && bus_err;

  logic tx_ok, rx_ok;
  auth_ksv_check #(.W(40), .ONES(20)) u_tx_chk (.ksv(tx_ksv),    .ok(tx_ok));
  auth_ksv_check #(.W(40), .ONES(20)) u_rx_chk (.ksv(cap[39:0]), .ok(rx_ok));

  logic             tmr_run, tmr_exp;
  logic [TMR_W-1:0] tmr_limit;
  always_comb begin
    tmr_run   = (st == LS_BUSY);
    tmr_limit = TMR_W'(POLL_GAP_MS);
    case (step)
      S_R0DLY:  tmr_limit = TMR_W'(R0_WAIT_MS);
      S_RESULT: tmr_limit = TMR_W'(RESULT_WAIT_MS);
      S_GAP:    tmr_limit = TMR_W'(POLL_GAP_MS);
      default:  tmr_run   = 1'b0;
    endcase
  end

  auth_ms_timer #(.CW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .tick(ms_tick),
    .limit(tmr_limit), .expired(tmr_exp)
  );

  logic key_ready, poll_miss, poll_last, res_pass, fail_now;
  assign key_ready = (key_state == KEY_OK_CODE) && (an_ready == 2'b11);
  assign poll_miss = (step == S_KEYWAIT && !key_ready) ||
                     (step == S_VMATCH && !v_match) ||
                     (step == S_RDY && xfer_end && !cap[5]);
  assign poll_last = (tries == TRY_W'(POLL_TRIES - 1));
  assign res_pass  = (step == S_RESULT) && auth_ok_evt && r0_match;
  assign fail_now  = (poll_miss && poll_last) || xfer_bad ||
                     (step == S_BKSV && xfer_end && !rx_ok) ||
                     (step == S_RESULT && !res_pass &&
                      (auth_fail_evt || auth_ok_evt || tmr_exp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= LS_IDLE; step <= S_KEYWAIT; ret_step <= S_KEYWAIT;
      xdata <= 1'b0; idx <= '0; cap <= '0; tries <= '0; retries <= '0;
      peer_ksv <= '0; peer_r0 <= '0; r0_load <= 1'b0;
      encrypt_en <= 1'b0; repeater <= 1'b0;
    end else begin
      r0_load <= 1'b0;
      case (st)
        LS_IDLE: if (start_req) begin
          if (tx_ok) begin
            st <= LS_BUSY; retries <= '0; encrypt_en <= 1'b0;
            step <= S_KEYWAIT; tries <= '0; repeater <= 1'b0;
          end else st <= LS_NOKEY;
        end
        LS_DONE: if (auth_fail_evt) begin
          st <= LS_FAILED; encrypt_en <= 1'b0;
        end
        LS_FAILED: begin
          if (abort_req || retries == RTY_W'(RETRY_MAX - 1)) begin
            st <= LS_IDLE; retries <= '0;
          end else begin
            retries <= retries + 1'b1; st <= LS_BUSY;
            step <= S_KEYWAIT; tries <= '0; repeater <= 1'b0;
          end
        end
        LS_BUSY: begin
          if (abort_req) begin
            st <= LS_IDLE; encrypt_en <= 1'b0; retries <= '0;
          end else if (fail_now) begin
            st <= LS_FAILED; encrypt_en <= 1'b0;
          end else begin
            if (in_bus && !xdata && cmd_ready) begin
              xdata <= 1'b1; idx <= '0;
            end
            if (wr_valid && wr_ready) idx <= idx + 1'b1;
            if (rd_ready && rd_valid) begin
              idx <= idx + 1'b1;
              cap[{idx[2:0], 3'b000} +: 8] <= rd_data;
            end
            case (step)
              S_KEYWAIT: if (key_ready) begin step <= S_CAPS; xdata <= 1'b0; end
              S_CAPS: if (xfer_end) begin
                repeater <= cap[6]; step <= S_AN; xdata <= 1'b0;
              end
              S_AN:   if (xfer_end) begin step <= S_AKSV; xdata <= 1'b0; end
              S_AKSV: if (xfer_end) begin step <= S_BKSV; xdata <= 1'b0; end
              S_BKSV: if (xfer_end) begin peer_ksv <= cap[39:0]; step <= S_R0DLY; end
              S_R0DLY: if (tmr_exp) begin step <= S_R0RD; xdata <= 1'b0; end
              S_R0RD: if (xfer_end) begin
                peer_r0 <= cap[15:0]; r0_load <= 1'b1; step <= S_RESULT;
              end
              S_RESULT: if (res_pass) begin
                encrypt_en <= 1'b1;
                if (repeater) begin step <= S_RDY; xdata <= 1'b0; tries <= '0; end
                else begin st <= LS_DONE; retries <= '0; end
              end
              S_RDY: if (xfer_end && cap[5]) begin step <= S_VMATCH; tries <= '0; end
              S_VMATCH: if (v_match) begin st <= LS_DONE; retries <= '0; end
              S_GAP: if (tmr_exp) begin step <= ret_step; xdata <= 1'b0; end
              default: ;
            endcase
            if (poll_miss) begin
              tries <= tries + 1'b1; ret_step <= step; step <= S_GAP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign link_state = st;

  AST_ENC_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    encrypt_en |-> (st == LS_BUSY || st == LS_DONE)); // R6
  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == LS_IDLE && st != LS_IDLE) |-> $past(start_req)); // R2
  AST_NOKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st == LS_NOKEY |=> st == LS_NOKEY); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort_req) |=>
      (cmd_valid && $stable(cmd_offset) && $stable(cmd_len) && $stable(cmd_write))); // R12
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retries < RTY_W'(RETRY_MAX)); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && (st == LS_BUSY || st == LS_FAILED)) |=> st == LS_IDLE); // R11
  AST_R0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    r0_load |=> !r0_load); // R5
  AST_REAUTH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_DONE && auth_fail_evt) |=> st == LS_FAILED); // R10
endmodule

// File: tb/tb_auth_link_seq.sv
`timescale 1ns/1ps
module tb_auth_link_seq;
  localparam int PT = 4, PG = 2, RW = 5, RS = 30, RM = 3;
  localparam logic [15:0] R0_VAL = 16'hA55A;
  localparam logic [39:0] GOODK = 40'h00000FFFFF, BK = 40'hF0F0F0F0F0;
  localparam logic [39:0] BAD21 = 40'h00001FFFFF, BAD19 = 40'h000007FFFF;

  typedef struct packed {
    logic [39:0] tx; logic [39:0] bk; logic [7:0] caps; logic [1:0] res;
    logic vm; logic [1:0] rdy; logic [1:0] ff;
    logic [2:0] est; logic eenc; logic [3:0] eatt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{GOODK, BK,    8'h00, 2'd0, 1'b0, 2'd0, 2'd0, 3'd3, 1'b1, 4'd1},
    '{BAD21, BK,    8'h00, 2'd0, 1'b0, 2'd0, 2'd0, 3'd0, 1'b0, 4'd0},
    '{GOODK, BAD19, 8'h00, 2'd0, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 4'd3},
    '{GOODK, BK,    8'h00, 2'd1, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 4'd3},
    '{GOODK, BK,    8'h00, 2'd2, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 4'd3},
    '{GOODK, BK,    8'h40, 2'd0, 1'b1, 2'd2, 2'd0, 3'd3, 1'b1, 4'd1},
    '{GOODK, BK,    8'h40, 2'd0, 1'b0, 2'd1, 2'd0, 3'd1, 1'b0, 4'd3},
    '{GOODK, BK,    8'h40, 2'd0, 1'b1, 2'd0, 2'd0, 3'd1, 1'b0, 4'd3},
    '{GOODK, BK,    8'h00, 2'd3, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 4'd3},
    '{BAD19, BK,    8'h00, 2'd0, 1'b0, 2'd0, 2'd0, 3'd0, 1'b0, 4'd0},
    '{GOODK, BK,    8'h00, 2'd0, 1'b0, 2'd0, 2'd2, 3'd3, 1'b1, 4'd3}
  };

  logic clk = 0, rst_n = 0, ms_tick = 0, start_req = 0, abort_req = 0;
  logic [39:0] tx_ksv = GOODK;
  logic [63:0] an_value = 64'h0123456789ABCDEF;
  logic [2:0] key_state = 3'd4;
  logic [1:0] an_ready = 2'b11;
  logic auth_ok_evt, cph_fail, tst_fail = 0, auth_fail_evt, r0_match, v_match;
  logic cmd_valid, cmd_write, wr_valid, rd_ready, rd_valid, bus_done, bus_err;
  logic [7:0] cmd_offset, wr_data, rd_data;
  logic [3:0] cmd_len;
  logic [39:0] peer_ksv;
  logic [15:0] peer_r0;
  logic r0_load, encrypt_en, repeater;
  logic [2:0] link_state;

  // per-run profile
  logic [39:0] v_bk; logic [7:0] v_caps; logic [1:0] v_res, v_rdy, fail_left;
  logic v_vm = 0, force_err = 0;
  // sink model state
  logic s_busy, s_wr; logic [7:0] s_off; logic [3:0] s_len, s_idx;
  logic [3:0] caps_cnt, pend;
  logic [63:0] an_got, ksv_got;
  int attempts, fails_seen, log_n, tick_total, t_bk, t_r0, cyc;
  logic r0_seen;
  logic [2:0] prev_st;
  logic [16:0] log_e [8];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  auth_link_seq #(.POLL_TRIES(PT), .POLL_GAP_MS(PG), .R0_WAIT_MS(RW),
                  .RESULT_WAIT_MS(RS), .RETRY_MAX(RM)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start_req(start_req),
    .abort_req(abort_req), .tx_ksv(tx_ksv), .an_value(an_value),
    .key_state(key_state), .an_ready(an_ready), .auth_ok_evt(auth_ok_evt),
    .auth_fail_evt(auth_fail_evt), .r0_match(r0_match), .v_match(v_match),
    .cmd_valid(cmd_valid), .cmd_ready(1'b1), .cmd_write(cmd_write),
    .cmd_offset(cmd_offset), .cmd_len(cmd_len), .wr_valid(wr_valid),
    .wr_ready(1'b1), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .bus_done(bus_done), .bus_err(bus_err),
    .peer_ksv(peer_ksv), .peer_r0(peer_r0), .r0_load(r0_load),
    .encrypt_en(encrypt_en), .repeater(repeater), .link_state(link_state));

  assign auth_fail_evt = cph_fail | tst_fail;
  assign v_match = v_vm;
  assign rd_valid = s_busy && !s_wr && (s_idx < s_len);

  always_comb begin
    rd_data = 8'h00;
    if (s_off == 8'h40)
      rd_data = v_caps | (((v_rdy != 0) && (caps_cnt >= 4'(v_rdy))) ? 8'h20 : 8'h00);
    else if (s_off == 8'h00) rd_data = v_bk[{s_idx[2:0], 3'b000} +: 8];
    else if (s_off == 8'h08) rd_data = (s_idx == 0) ? R0_VAL[7:0] : R0_VAL[15:8];
  end

  // millisecond tick: one pulse every 4 clocks
  logic [1:0] div = 0;
  always @(posedge clk) begin
    div <= div + 1'b1;
    ms_tick <= (div == 2'd3);
    if (ms_tick) tick_total <= tick_total + 1;
  end

  // bus engine + sink + cipher model
  always @(posedge clk) begin
    if (!rst_n) begin
      s_busy <= 0; s_wr <= 0; s_off <= 0; s_len <= 0; s_idx <= 0;
      bus_done <= 0; bus_err <= 0; caps_cnt <= 0; pend <= 0;
      auth_ok_evt <= 0; cph_fail <= 0; r0_match <= 0; r0_seen <= 0;
      an_got <= 0; ksv_got <= 0; attempts <= 0; fails_seen <= 0; log_n <= 0;
      t_bk <= -1; t_r0 <= -1; prev_st <= 3'd1; tick_total <= 0;
    end else begin
      bus_done <= 0; bus_err <= 0; auth_ok_evt <= 0; cph_fail <= 0;
      prev_st <= link_state;
      if (link_state == 3'd4 && prev_st != 3'd4) fails_seen <= fails_seen + 1;
      if (cmd_valid && !s_busy) begin
        s_busy <= 1; s_wr <= cmd_write; s_off <= cmd_offset; s_len <= cmd_len; s_idx <= 0;
        if (log_n < 8) log_e[log_n] <= {cmd_write, cmd_offset, 4'd0, cmd_len};
        log_n <= log_n + 1;
        if (cmd_write && cmd_offset == 8'h18) attempts <= attempts + 1;
        if (cmd_offset == 8'h40) caps_cnt <= caps_cnt + 1;
        if (cmd_offset == 8'h08 && t_r0 < 0) t_r0 <= tick_total;
      end else if (s_busy) begin
        if (s_idx < s_len) begin
          if (s_wr && wr_valid) begin
            if (s_off == 8'h18) an_got[{s_idx[2:0], 3'b000} +: 8] <= wr_data;
            if (s_off == 8'h10) ksv_got[{s_idx[2:0], 3'b000} +: 8] <= wr_data;
            s_idx <= s_idx + 1;
          end
          if (!s_wr && rd_ready) s_idx <= s_idx + 1;
        end else begin
          s_busy <= 0;
          if (force_err && s_off == 8'h40) bus_err <= 1;
          else bus_done <= 1;
          if (s_off == 8'h00 && t_bk < 0) t_bk <= tick_total;
        end
      end
      if (r0_load) begin pend <= 4'd3; caps_cnt <= 0; r0_seen <= 1; end
      else if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 4'd1) begin
          if (fail_left != 0) begin cph_fail <= 1; fail_left <= fail_left - 1; end
          else if (v_res == 2'd0) begin auth_ok_evt <= 1; r0_match <= (peer_r0 == R0_VAL); end
          else if (v_res == 2'd1) cph_fail <= 1;
          else if (v_res == 2'd3) begin auth_ok_evt <= 1; r0_match <= 0; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1; @(negedge clk); start_req = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8000 && (link_state == 3'd2 || link_state == 3'd4); k++)
      @(negedge clk);
  endtask

  task automatic set_profile(input vec_t v);
    tx_ksv = v.tx; v_bk = v.bk; v_caps = v.caps; v_res = v.res;
    v_vm = v.vm; v_rdy = v.rdy; fail_left = v.ff;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    set_profile(VECS[0]);
    do_reset();
    chk("R1 state", link_state, 3'd1);
    chk("R1 enc", encrypt_en, 0);
    chk("R1 cmd_valid", cmd_valid, 0);

    for (int i = 0; i < NV; i++) begin
      set_profile(VECS[i]);
      do_reset();
      pulse_start();
      settle();
      chk($sformatf("R2/R6/R7/R9 v%0d state", i), link_state, VECS[i].est);
      chk($sformatf("R6/R9 v%0d enc", i), encrypt_en, VECS[i].eenc);
      chk($sformatf("R4/R8/R9 v%0d attempts", i), attempts, VECS[i].eatt);
      if (i == 0) begin
        chk("R3 cmd0", log_e[0], {1'b0, 8'h40, 4'd0, 4'd1});
        chk("R3 cmd1", log_e[1], {1'b1, 8'h18, 4'd0, 4'd8});
        chk("R3 cmd2", log_e[2], {1'b1, 8'h10, 4'd0, 4'd5});
        chk("R3 cmd3", log_e[3], {1'b0, 8'h00, 4'd0, 4'd5});
        chk("R5 cmd4", log_e[4], {1'b0, 8'h08, 4'd0, 4'd2});
        chk("R3 an bytes", an_got, an_value);
        chk("R3 ksv bytes", ksv_got, {24'd0, tx_ksv});
        chk("R4 peer_ksv", peer_ksv, BK);
        chk("R5 peer_r0", peer_r0, R0_VAL);
        chk("R5 delay ok", (t_r0 - t_bk) >= RW - 1, 1);
        chk("R7 receiver flag", repeater, 0);
        // R2: start while authenticated has no effect
        pulse_start();
        repeat (60) @(negedge clk);
        chk("R2 start ignored state", link_state, 3'd3);
        chk("R2 start ignored attempts", attempts, 1);
        // R10: failure while authenticated re-authenticates
        tst_fail = 1; @(negedge clk); tst_fail = 0;
        chk("R10 failed state", link_state, 3'd4);
        chk("R10 enc cleared", encrypt_en, 0);
        settle();
        chk("R10 reauth state", link_state, 3'd3);
        chk("R10 reauth attempts", attempts, 2);
      end
      if (i == 5) chk("R7 repeater flag", repeater, 1);
      if (i == 10) begin
        // R9: success zeroed the count, so one event + one fail still recovers
        fail_left = 2'd1;
        tst_fail = 1; @(negedge clk); tst_fail = 0;
        settle();
        chk("R9 count zeroed state", link_state, 3'd3);
        chk("R9 count zeroed attempts", attempts, 5);
      end
    end

    // R11: abort during result wait
    set_profile(VECS[4]);
    do_reset();
    pulse_start();
    for (int k = 0; k < 4000 && !r0_seen; k++) @(negedge clk);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R11 abort state", link_state, 3'd1);
    chk("R11 abort enc", encrypt_en, 0);
    repeat (300) @(negedge clk);
    chk("R11 no restart", attempts, 1);
    chk("R11 still idle", link_state, 3'd1);

    // R8: key never ready
    set_profile(VECS[0]);
    key_state = 3'd2;
    do_reset();
    pulse_start();
    settle();
    chk("R8 key wait state", link_state, 3'd1);
    chk("R8 key wait fails", fails_seen, RM);
    chk("R8 key wait no cmd", log_n, 0);
    key_state = 3'd4;

    // R12: bus error on capability read
    force_err = 1;
    do_reset();
    pulse_start();
    settle();
    chk("R12 bus err state", link_state, 3'd1);
    chk("R12 bus err fails", fails_seen, RM);
    chk("R12 bus err attempts", attempts, 0);
    force_err = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule